// File: doc/BRIEF.md
# Single-Byte Sample Fetch DMA

This block takes over the CPU bus to fetch one byte for an audio sample unit. A fetch request arrives with a 16-bit address and a one-bit kind that separates an initial load from a reload. Once accepted, the block stalls the CPU. It then steps through a short sequence that lines the read up with the CPU's alternating get/put cycle phase, and issues one read command on the bus. The command stays up until the bus reports that the read is done.

One clock edge is one CPU cycle. The get/put phase bit is kept inside the block and toggles on a separate phase-advance strobe. Every sequencing decision made at an edge uses the phase value from before that edge's toggle.

Both data-carrying interfaces use valid/ready. A request transfers when `req_valid` and `req_ready` are both high. `req_ready` is high exactly when no fetch is active, so any request offered during a fetch is simply not taken. The read command transfers when `cmd_valid` and `cmd_ready` are both high. The block holds `cmd_valid` and `cmd_addr` steady for as long as `cmd_ready` stays low.

Top module: `smp_fetch_dma`

## Requirements
- R1: After reset, and after a reset applied in the middle of a fetch, the block is idle: `req_ready`=1, `cmd_valid`=0, `cpu_stall`=0, and the internal phase is get (0).
- R2: The phase bit flips at a clock edge only when `phase_adv` is 1. With the strobe held at 0, the phase, and therefore any wait on it, stays frozen.
- R3: `req_ready` is 1 exactly when no fetch is active. A request offered while a fetch is active is ignored: the address of the later command is still the one that was accepted.
- R4: A load request (`req_kind`=0) waits until the pre-toggle phase is get (0). With the strobe toggling every cycle and the accept cycle counted as cycle 0, `cmd_valid` first rises in cycle 2 if the phase at accept is get, and in cycle 3 if it is put. If the phase is frozen at put, the read never starts.
- R5: A reload request (`req_kind`=1) waits until the pre-toggle phase is put (1). With the strobe toggling every cycle, `cmd_valid` first rises in cycle 3 if the phase at accept is put, and in cycle 4 if it is get.
- R6: After the dummy cycle, the block goes straight to the read when the phase is put. Otherwise it inserts one align cycle first. With the phase frozen, a load accepted at get reads in cycle 3, and a reload accepted at put reads in cycle 2.
- R7: In the read state, `cmd_valid`=1 and `cmd_addr` carries the captured address on every cycle until `cmd_ready` is 1. In the cycle after that acknowledge, the block is idle.
- R8: `cpu_stall` is 1 on every cycle of a fetch, from the accept cycle through the acknowledged read cycle, and 0 otherwise. `cmd_valid` is 1 only in the read state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge per CPU cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request offered |
| req_ready | output | 1 | High when no fetch is active |
| req_addr | input | ADDR_W | Byte address to fetch |
| req_kind | input | 1 | 0 = initial load, 1 = reload |
| phase_adv | input | 1 | Toggles the get/put phase at this edge |
| cmd_valid | output | 1 | Bus read command present |
| cmd_addr | output | ADDR_W | Address of the read command |
| cmd_ready | input | 1 | Read done; completes the fetch |
| cpu_stall | output | 1 | CPU bus is held for the fetch |

## Verification
The main function is exercised with both request kinds, each accepted at both start phases, with the phase strobe toggling every cycle. These four cases separate the load wait from the reload wait, and show whether the align cycle is inserted or skipped. The same cases are repeated with the phase strobe frozen, which shows that the dummy-to-read decision reads the phase rather than counting cycles. Each vector also holds off the acknowledge for a few cycles and offers a conflicting request mid-fetch, which shows that the command is held and that busy-time requests are dropped. Directed cases cover a load stuck at a frozen put phase and a reset during a read.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_DUMMY = 2'd1,
    ST_ALIGN = 2'd2,
    ST_READ  = 2'd3
  } fetch_st_t;

  localparam logic PH_GET = 1'b0;
  localparam logic PH_PUT = 1'b1;
  // kind 0 (load) halts on get, kind 1 (reload) halts on put
  localparam logic KIND_LOAD   = 1'b0;
  localparam logic KIND_RELOAD = 1'b1;
endpackage

// File: rtl/sfd_phase.sv
module sfd_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  output logic phase_o
);
  import sfd_pkg::*;
  logic phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_GET;
    else if (adv_i) phase_q <= ~phase_q;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/sfd_addr_hold.sv
module sfd_addr_hold #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else if (load_i) addr_q <= addr_i;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/sfd_seq.sv
module sfd_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic kind_i,
  input  logic phase_i,
  input  logic ack_i,
  output logic active_o,
  output logic in_read_o
);
  import sfd_pkg::*;

  fetch_st_t st_q, st_d;
  logic      active_q, active_d;
  logic      kind_q, kind_d;

  always_comb begin
    st_d     = st_q;
    active_d = active_q;
    kind_d   = kind_q;
    if (!active_q) begin
      if (fire_i) begin
        active_d = 1'b1;
        kind_d   = kind_i;
        // the accept cycle already evaluates the halt condition
        st_d     = (phase_i == kind_i) ? ST_DUMMY : ST_WAIT;
      end
    end else begin
      unique case (st_q)
        ST_WAIT:  if (phase_i == kind_q) st_d = ST_DUMMY;
        ST_DUMMY: st_d = (phase_i == PH_PUT) ? ST_READ : ST_ALIGN;
        ST_ALIGN: st_d = ST_READ;
        ST_READ: begin
          if (ack_i) begin
            active_d = 1'b0;
            st_d     = ST_WAIT;
          end
        end
        default:  st_d = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_WAIT;
      active_q <= 1'b0;
      kind_q   <= KIND_LOAD;
    end else begin
      st_q     <= st_d;
      active_q <= active_d;
      kind_q   <= kind_d;
    end
  end

  assign active_o  = active_q;
  assign in_read_o = active_q && (st_q == ST_READ);
endmodule

// File: rtl/smp_fetch_dma.sv
module smp_fetch_dma #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_kind,
  input  logic              phase_adv,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_ready,
  output logic              cpu_stall
);
  logic phase;
  logic active;
  logic in_read;
  logic fire;
  logic ack;

  assign fire = req_valid && !active;
  assign ack  = in_read && cmd_ready;

  sfd_phase u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_i   (phase_adv),
    .phase_o (phase)
  );

  sfd_addr_hold #(.ADDR_W(ADDR_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (fire),
    .addr_i (req_addr),
    .addr_o (cmd_addr)
  );

  sfd_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (fire),
    .kind_i    (req_kind),
    .phase_i   (phase),
    .ack_i     (ack),
    .active_o  (active),
    .in_read_o (in_read)
  );

  assign req_ready = !active;
  assign cmd_valid = in_read;
  assign cpu_stall = active || fire;
endmodule

// File: rtl/smp_fetch_dma_chk.sv
module smp_fetch_dma_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_ready,
  input logic              cpu_stall
);
  AST_CMD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cpu_stall) else $error("cmd without stall"); // R8

  AST_BUSY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> cpu_stall) else $error("busy without stall"); // R8

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready) else $error("accept not busy"); // R3

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr))) else $error("cmd dropped"); // R7

  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (req_ready && !cmd_valid)) else $error("not idle after ack"); // R7

  AST_READ_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> !cmd_valid) else $error("cmd from idle"); // R8
endmodule

bind smp_fetch_dma smp_fetch_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cmd_valid (cmd_valid),
  .cmd_addr  (cmd_addr),
  .cmd_ready (cmd_ready),
  .cpu_stall (cpu_stall)
);

// File: tb/smp_fetch_dma_bench.sv
module smp_fetch_dma_bench;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_kind = 1'b0;
  logic          phase_adv = 1'b0;
  logic          cmd_valid;
  logic [AW-1:0] cmd_addr;
  logic          cmd_ready = 1'b0;
  logic          cpu_stall;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic ph = 1'b0;  // bench view of phase: 0 get, 1 put

  always #10 clk = ~clk;

  smp_fetch_dma #(.ADDR_W(AW)) u_smp_fetch_dma (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind), .phase_adv(phase_adv),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_ready(cmd_ready),
    .cpu_stall(cpu_stall)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 5000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one CPU cycle with inputs set at negedge; bench phase model updated at edge
  task automatic drive(input logic v, input logic [AW-1:0] a, input logic k,
                       input logic adv, input logic rdy);
    @(negedge clk);
    req_valid = v; req_addr = a; req_kind = k; phase_adv = adv; cmd_ready = rdy;
    #1;
  endtask

  task automatic edge_done();
    @(posedge clk);
    if (phase_adv) ph = ~ph;
  endtask

  // kind, phase at accept, strobe on, cycles to read, ack hold-off, address
  typedef struct packed {
    logic       kind;
    logic       ph0;
    logic       adv;
    logic [3:0] lat;
    logic [3:0] hold;
    logic [15:0] addr;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 4'd2, 4'd0, 16'hC000},  // R4 load at get
    '{1'b0, 1'b1, 1'b1, 4'd3, 4'd2, 16'h1234},  // R4 load at put
    '{1'b1, 1'b1, 1'b1, 4'd3, 4'd1, 16'hFFFF},  // R5 reload at put
    '{1'b1, 1'b0, 1'b1, 4'd4, 4'd3, 16'h8001},  // R5 reload at get
    '{1'b0, 1'b0, 1'b0, 4'd3, 4'd1, 16'h00A5},  // R6 frozen get, align taken
    '{1'b1, 1'b1, 1'b0, 4'd2, 4'd0, 16'h5A5A}   // R6 frozen put, align skipped
  };
  localparam string TAGS [NV] = '{"R4", "R4", "R5", "R5", "R6", "R6"};

  initial begin
    // R1 reset state
    repeat (2) drive(1'b0, '0, 1'b0, 1'b0, 1'b0);
    chk("R1 ready in reset", {31'd0, req_ready}, 32'd1);
    edge_done();
    rst_n = 1'b1;
    drive(1'b0, '0, 1'b0, 1'b0, 1'b0);
    chk("R1 ready", {31'd0, req_ready}, 32'd1);
    chk("R1 cmd_valid", {31'd0, cmd_valid}, 32'd0);
    chk("R1 stall", {31'd0, cpu_stall}, 32'd0);
    edge_done();

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int last;
      v = VECS[i];
      while (ph != v.ph0) begin
        drive(1'b0, '0, 1'b0, 1'b1, 1'b0);
        chk("R3 idle ready", {31'd0, req_ready}, 32'd1);
        edge_done();
      end
      last = int'(v.lat) + int'(v.hold);
      for (int n = 0; n <= last; n++) begin
        drive(n <= 1, (n == 0) ? v.addr : ~v.addr, (n == 0) ? v.kind : ~v.kind,
              v.adv, n == last);
        chk("R8 stall during fetch", {31'd0, cpu_stall}, 32'd1);
        if (n > 0) chk("R3 busy not ready", {31'd0, req_ready}, 32'd0);
        chk(TAGS[i], {31'd0, cmd_valid}, {31'd0, n >= int'(v.lat)});
        if (n >= int'(v.lat)) chk("R7 held address", {16'd0, cmd_addr}, {16'd0, v.addr});
        edge_done();
      end
      drive(1'b0, '0, 1'b0, 1'b0, 1'b0);
      chk("R7 idle after ack", {29'd0, req_ready, cmd_valid, cpu_stall}, 32'h4);
      edge_done();
    end

    // R2/R4: load stuck at frozen put phase never reads
    while (ph != 1'b1) begin drive(1'b0, '0, 1'b0, 1'b1, 1'b0); edge_done(); end
    drive(1'b1, 16'h2468, 1'b0, 1'b0, 1'b0);
    edge_done();
    for (int n = 1; n <= 6; n++) begin
      drive(1'b0, '0, 1'b0, 1'b0, 1'b0);
      chk("R2 frozen phase no read", {30'd0, cmd_valid, cpu_stall}, 32'h1);
      edge_done();
    end
    // resume strobe at put: cycle k await, k+1 dummy, k+2 read, valid at k+3
    for (int n = 0; n < 3; n++) begin
      drive(1'b0, '0, 1'b0, 1'b1, 1'b0);
      chk("R4 resumed wait", {31'd0, cmd_valid}, 32'd0);
      edge_done();
    end
    drive(1'b0, '0, 1'b0, 1'b1, 1'b0);
    chk("R4 resumed read", {31'd0, cmd_valid}, 32'd1);
    chk("R7 resumed addr", {16'd0, cmd_addr}, 32'h2468);

    // R1: reset during read
    rst_n = 1'b0;
    edge_done();
    ph = 1'b0;
    drive(1'b0, '0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    chk("R1 reset mid fetch", {29'd0, req_ready, cmd_valid, cpu_stall}, 32'h4);
    edge_done();
    // phase back at get: load at get with strobe reads in cycle 2
    for (int n = 0; n <= 2; n++) begin
      drive(n == 0, 16'h0F0F, 1'b0, 1'b1, n == 2);
      chk("R1 phase get after reset", {31'd0, cmd_valid}, {31'd0, n == 2});
      edge_done();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule